// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This block keeps the interrupt state of an 8-bit timer/counter. It watches the live counter value against two compare registers and takes a one-cycle overflow strobe from the counter. Each of the three events sets a sticky flag. Software can mask each source. A per-source interrupt request is raised only while that flag is set, its mask bit is set and the global interrupt enable is high.

Software reaches the two compare registers, the mask register and the flag register through a small register port. Writes take effect at the clock edge, and reads are combinational. A flag is cleared in one of two ways. The interrupt vector logic can return a one-hot acknowledge pulse, or software can write a one to the flag's bit. If a new event for a flag arrives in the same cycle as a clear, the event wins.

A compare channel sets its flag once for each period of equality. A counter that stops on the compare value therefore does not set the flag again after software has cleared it.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset, both compare registers, the mask register and the flag register read as zero, and all interrupt requests are low.
- R2: When the counter becomes equal to compare A, flag bit 1 is set at the next clock edge. When it becomes equal to compare B, flag bit 2 is set at the next clock edge.
- R3: A compare match sets its flag only on the cycle where equality begins. If the counter stays equal to the compare value, a flag that has been cleared stays cleared.
- R4: An overflow strobe that is high at a clock edge sets flag bit 0 at that edge.
- R5: A write to the flag register (address 3) clears each flag whose data bit is one. A zero data bit leaves that flag unchanged.
- R6: An acknowledge pulse clears the flag of the same bit index: bit 0 for overflow, bit 1 for compare A, bit 2 for compare B. At most one acknowledge bit is high in any cycle.
- R7: If a flag's set event and a clear (acknowledge or write-one) fall in the same cycle, the flag ends up set.
- R8: Request bit i is high exactly when the global enable, mask bit i and flag bit i are all one. The request falls in the cycle after its flag is cleared.
- R9: Bits 7:3 of the mask register and of the flag register always read as zero, and writes to those bits have no effect.
- R10: Compare A (address 0), compare B (address 1) and the mask register (address 2) can be read and written. Mask bit 0 enables overflow, bit 1 enables compare A and bit 2 enables compare B.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_val | input | 8 | Live counter value |
| ovf_strobe | input | 1 | One-cycle overflow event from the counter |
| gie | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register select: 0 compare A, 1 compare B, 2 mask, 3 flags |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Combinational read data for the register at addr |
| ack | input | 3 | One-hot acknowledge from the vector logic, one pulse per clear |
| irq_req | output | 3 | Interrupt requests: bit 0 overflow, bit 1 compare A, bit 2 compare B |

## Verification
The set path and the clear path of a flag can act in the same cycle. This happens when an event arrives while the vector logic acknowledges the flag or software writes a one to it. The bench sets this up with an overflow strobe driven in the same cycle as an acknowledge, and again in the same cycle as a write-one. It also moves the counter onto compare A in the same cycle as a write-one clear of that flag. In each case the flag register is read back after the edge and must still show the flag set. A separate directed step holds the counter on a compare value after a clear, to show that the continuing equality does not count as a new event.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  localparam int SRC_N    = 3;
  localparam int CMP_N    = 2;
  localparam int SRC_OVF  = 0;
  localparam int SRC_CMPA = 1;
  localparam int SRC_CMPB = 2;

  typedef enum logic [1:0] {
    REG_CMPA = 2'd0,
    REG_CMPB = 2'd1,
    REG_MASK = 2'd2,
    REG_FLAG = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_cmp_edge.sv
module tmr_cmp_edge #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cnt_i,
  input  logic [DATA_W-1:0] cmp_i,
  output logic              hit_o
);
  logic eq_now;
  logic eq_q;

  always_comb begin
    eq_now = (cnt_i == cmp_i);
    hit_o  = eq_now & ~eq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq_now;
  end

  // R3
  once_per_episode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o);
endmodule

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
  parameter int SRC_N = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] set_i,
  input  logic [SRC_N-1:0] clr_i,
  input  logic [SRC_N-1:0] mask_i,
  input  logic             gie_i,
  output logic [SRC_N-1:0] flag_o,
  output logic [SRC_N-1:0] irq_o
);
  logic [SRC_N-1:0] flag_q;
  logic [SRC_N-1:0] flag_d;
  logic [SRC_N-1:0] flag_en;

  for (genvar i = 0; i < SRC_N; i++) begin : g_src
    always_comb begin
      flag_en[i] = set_i[i] | clr_i[i];
      flag_d[i]  = set_i[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flag_q[i] <= 1'b0;
      else if (flag_en[i]) flag_q[i] <= flag_d[i];
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[i] |=> flag_o[i]);
    // R5
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !set_i[i]) |=> !flag_o[i]);
    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i[i] && !set_i[i]) |=> $stable(flag_o[i]));
    // R8
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_o[i]) |-> !irq_o[i]);
  end

  always_comb begin
    flag_o = flag_q;
    irq_o  = flag_q & mask_i & {SRC_N{gie_i}};
  end
endmodule

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs
  import tmr_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [1:0]                  addr,
  input  logic [DATA_W-1:0]           wr_data,
  input  logic [SRC_N-1:0]            flag_i,
  output logic [CMP_N-1:0][DATA_W-1:0] cmp_o,
  output logic [SRC_N-1:0]            mask_o,
  output logic [SRC_N-1:0]            wclr_o,
  output logic [DATA_W-1:0]           rd_data
);
  logic [CMP_N-1:0][DATA_W-1:0] cmp_q;
  logic [CMP_N-1:0]             cmp_en;
  logic [SRC_N-1:0]             mask_q;
  logic                         mask_en;
  reg_sel_e                     sel;

  assign sel = reg_sel_e'(addr);

  always_comb begin
    cmp_en[0] = wr_en && (sel == REG_CMPA);
    cmp_en[1] = wr_en && (sel == REG_CMPB);
    mask_en   = wr_en && (sel == REG_MASK);
    wclr_o    = (wr_en && (sel == REG_FLAG)) ? wr_data[SRC_N-1:0] : '0;
  end

  for (genvar c = 0; c < CMP_N; c++) begin : g_cmp
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cmp_q[c] <= '0;
      else if (cmp_en[c]) cmp_q[c] <= wr_data;
    end

    // R10
    cmp_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_en[c] |=> (cmp_o[c] == $past(wr_data)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= wr_data[SRC_N-1:0];
  end

  always_comb begin
    cmp_o   = cmp_q;
    mask_o  = mask_q;
    rd_data = '0;
    case (sel)
      REG_CMPA: rd_data = cmp_q[0];
      REG_CMPB: rd_data = cmp_q[1];
      REG_MASK: rd_data[SRC_N-1:0] = mask_q;
      default:  rd_data[SRC_N-1:0] = flag_i;
    endcase
  end

  // R9
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == REG_MASK || sel == REG_FLAG) |-> (rd_data[DATA_W-1:SRC_N] == '0));
endmodule

// File: rtl/tmr_irq_unit.sv
module tmr_irq_unit
  import tmr_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cnt_val,
  input  logic              ovf_strobe,
  input  logic              gie,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic [SRC_N-1:0]  ack,
  output logic [SRC_N-1:0]  irq_req
);
  logic [CMP_N-1:0][DATA_W-1:0] cmp_val;
  logic [SRC_N-1:0]             mask_q;
  logic [SRC_N-1:0]             flag_q;
  logic [SRC_N-1:0]             wclr;
  logic [SRC_N-1:0]             set_ev;
  logic [SRC_N-1:0]             clr_ev;
  logic [CMP_N-1:0]             cmp_hit;

  tmr_irq_regs #(.DATA_W(DATA_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wr_data (wr_data),
    .flag_i  (flag_q),
    .cmp_o   (cmp_val),
    .mask_o  (mask_q),
    .wclr_o  (wclr),
    .rd_data (rd_data)
  );

  for (genvar c = 0; c < CMP_N; c++) begin : g_chan
    tmr_cmp_edge #(.DATA_W(DATA_W)) edge_i (
      .clk   (clk),
      .rst_n (rst_n),
      .cnt_i (cnt_val),
      .cmp_i (cmp_val[c]),
      .hit_o (cmp_hit[c])
    );
  end

  always_comb begin
    set_ev           = '0;
    set_ev[SRC_OVF]  = ovf_strobe;
    set_ev[SRC_CMPA] = cmp_hit[0];
    set_ev[SRC_CMPB] = cmp_hit[1];
    clr_ev           = ack | wclr;
  end

  tmr_irq_flags #(.SRC_N(SRC_N)) flags_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_ev),
    .clr_i  (clr_ev),
    .mask_i (mask_q),
    .gie_i  (gie),
    .flag_o (flag_q),
    .irq_o  (irq_req)
  );

  // R6
  ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack));
  // R8
  irq_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq_req == '0));
endmodule

// File: tb/tmr_irq_unit_tb_top.sv
module tmr_irq_unit_tb_top;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cnt_val;
  logic       ovf_strobe;
  logic       gie;
  logic       wr_en;
  logic [1:0] addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic [2:0] ack;
  logic [2:0] irq_req;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  // {gie, mask[2:0], expected irq[2:0]} with all three flags set (R8)
  localparam logic [6:0] VEC [8] = '{
    7'b1_001_001, 7'b1_010_010, 7'b1_100_100, 7'b1_111_111,
    7'b0_111_000, 7'b0_101_000, 7'b1_000_000, 7'b1_110_110
  };

  tmr_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .ovf_strobe(ovf_strobe),
    .gie(gie), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .ack(ack), .irq_req(irq_req)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 5000) begin
      fails = fails + 1;
      $display("FAIL watchdog expired act=%0d exp<=5000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    chk(req, rd_data, exp);
  endtask

  initial begin
    rst_n = 1'b0; cnt_val = 8'h55; ovf_strobe = 1'b0; gie = 1'b0;
    wr_en = 1'b0; addr = 2'd0; wr_data = 8'h00; ack = 3'b000;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    rd("R1 cmpA", 2'd0, 8'h00);
    rd("R1 cmpB", 2'd1, 8'h00);
    rd("R1 mask", 2'd2, 8'h00);
    rd("R1 flag", 2'd3, 8'h00);
    chk("R1 irq", {5'b0, irq_req}, 8'h00);

    // R10 register access, R9 reserved mask bits
    wr(2'd0, 8'h10);
    wr(2'd1, 8'h20);
    wr(2'd2, 8'hFF);
    rd("R10 cmpA", 2'd0, 8'h10);
    rd("R10 cmpB", 2'd1, 8'h20);
    rd("R9 mask reserved", 2'd2, 8'h07);
    wr(2'd3, 8'hF8);
    rd("R9 flag reserved", 2'd3, 8'h00);

    // R2 compare matches
    cnt_val = 8'h10; step();
    rd("R2 cmpA flag", 2'd3, 8'h02);
    cnt_val = 8'h20; step();
    rd("R2 cmpB flag", 2'd3, 8'h06);

    // R4 overflow
    ovf_strobe = 1'b1; step(); ovf_strobe = 1'b0;
    rd("R4 ovf flag", 2'd3, 8'h07);

    // R8 table of gating vectors, flags all set
    for (int k = 0; k < 8; k++) begin
      gie = VEC[k][6];
      wr(2'd2, {5'b0, VEC[k][5:3]});
      #1;
      chk("R8 irq gating", {5'b0, irq_req}, {5'b0, VEC[k][2:0]});
    end

    gie = 1'b1;
    wr(2'd2, 8'h07);
    // R5 write-one clear, write-zero hold; R8 request drop
    wr(2'd3, 8'h02);
    rd("R5 write one clears", 2'd3, 8'h05);
    chk("R8 irq after clear", {5'b0, irq_req}, 8'h05);
    wr(2'd3, 8'h00);
    rd("R5 write zero holds", 2'd3, 8'h05);

    // R3 counter held at compare B after clear
    wr(2'd3, 8'h04);
    rd("R3 cleared", 2'd3, 8'h01);
    step(); step();
    rd("R3 no re-set while equal", 2'd3, 8'h01);

    // R6 acknowledge clears overflow flag
    ack = 3'b001; step(); ack = 3'b000;
    rd("R6 ack clears", 2'd3, 8'h00);
    chk("R6 irq low", {5'b0, irq_req}, 8'h00);

    // R7 set beats ack
    ovf_strobe = 1'b1; ack = 3'b001; step();
    ovf_strobe = 1'b0; ack = 3'b000;
    rd("R7 set vs ack", 2'd3, 8'h01);
    // R7 set beats write-one
    ovf_strobe = 1'b1; wr(2'd3, 8'h01); ovf_strobe = 1'b0;
    rd("R7 set vs write", 2'd3, 8'h01);
    // R7 compare A match beats write-one clear
    cnt_val = 8'h11; step();
    cnt_val = 8'h10; wr(2'd3, 8'h02);
    rd("R7 cmp vs write", 2'd3, 8'h03);
    // R6 acknowledge of compare A only
    ack = 3'b010; step(); ack = 3'b000;
    rd("R6 ack cmpA", 2'd3, 8'h01);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule